// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside an arithmetic/logic datapath and turns the facts of a finished operation into the six status flags: sign, zero, auxiliary carry, parity, carry and overflow. The datapath hands it both operands, the result it produced and the carry out of its adder. It also gives the operand width (byte or word), the operation class (add, subtract or logic) and a write strobe.

The flags live in a six-bit register that is always visible on a parallel read port. They change only on a rising clock edge with the strobe high. A subtraction is assumed to be carried out by the datapath as `a + ~b + 1`, so the adder carry-out arrives inverted relative to a borrow. The block undoes that inversion. Parity always examines the low eight result bits, and auxiliary carry always concerns bit 3, whether the operation is byte or word.

Register bit positions on `flags_q`: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.

Top module: `alu_flag_unit`

## Requirements
- R1: A clock edge with `rst_n` low clears all six bits of `flags_q` to 0.
- R2: On a write, the sign bit (bit 4) takes the result's top bit at the selected width: bit 15 for word (`word_sel`=1), bit 7 for byte.
- R3: On a write, the zero bit (bit 3) is 1 exactly when every result bit at the selected width is 0; in byte mode result bits 15:8 are ignored.
- R4: On a write, the parity bit (bit 1) is 1 when result bits 7:0 hold an even count of ones, in both widths.
- R5: On an add write, auxiliary carry (bit 2) is 1 when the low nibbles carry out of bit 3. On a subtract write, it is 1 when the low nibble of `op_b` exceeds that of `op_a`, meaning a borrow.
- R6: On an add write, carry (bit 0) equals `carry_out`. On a subtract write, carry equals the inverse of `carry_out`, which is a borrow out of the top bit.
- R7: On an add write, overflow (bit 5) is 1 when both operand signs agree and the result sign differs from them. On a subtract write, it is 1 when the operand signs differ and the result sign differs from `op_a`'s sign. Signs are taken at the selected width.
- R8: A logic write (`op_class`=2) clears carry, auxiliary carry and overflow, whatever `carry_out` is.
- R9: With `wr_en` low, `flags_q` keeps its value across clock edges whatever the other inputs do.
- R10: The spare class code `op_class`=3 behaves exactly like a logic write. Codes 0 and 1 select add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | DW | First operand |
| op_b | input | DW | Second operand |
| result | input | DW | Datapath result |
| carry_out | input | 1 | Adder carry out of the selected width's top bit |
| word_sel | input | 1 | 1 = word width, 0 = byte width |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 logic |
| wr_en | input | 1 | Flag write strobe |
| flags_q | output | 6 | Flag register read port |

## Verification
The assertions assume that `result` and `carry_out` are consistent with the operands for add and subtract. In particular, a zero result must never come with a set top bit. The bench therefore derives every arithmetic result and carry from the operands themselves, using the `a + ~b + 1` form for subtraction. Only logic operations and the ignored upper byte in byte mode receive free-running values. On those, the stimulus deliberately raises `carry_out` and fills result bits 15:8 with junk, to show that these inputs are ignored.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] result,
  input  logic          carry_out,
  input  logic          word_sel,
  input  logic [1:0]    op_class,
  input  logic          wr_en,
  output logic [5:0]    flags_q
);
  localparam int HB = DW / 2;

  logic sa, sb, sr, is_add, is_sub, zero_w, zero_b;
  logic [5:0] nxt;

  assign is_add = (op_class == 2'd0);
  assign is_sub = (op_class == 2'd1);

  assign sa = word_sel ? op_a[DW-1]   : op_a[HB-1];
  assign sb = word_sel ? op_b[DW-1]   : op_b[HB-1];
  assign sr = word_sel ? result[DW-1] : result[HB-1];

  assign zero_b = ~|result[HB-1:0];
  assign zero_w = zero_b & ~|result[DW-1:HB];

  assign nxt[0] = (is_add & carry_out) | (is_sub & ~carry_out);
  assign nxt[1] = ~^result[7:0];
  assign nxt[2] = (is_add | is_sub) & (op_a[4] ^ op_b[4] ^ result[4]);
  assign nxt[3] = word_sel ? zero_w : zero_b;
  assign nxt[4] = sr;
  assign nxt[5] = (is_add & (sa == sb) & (sr != sa)) |
                  (is_sub & (sa != sb) & (sr != sa));

  always_ff @(posedge clk) begin
    if (!rst_n)     flags_q <= '0;
    else if (wr_en) flags_q <= nxt;
  end
endmodule

module alu_flag_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          word_sel,
  input logic [1:0]    op_class,
  input logic          wr_en,
  input logic [5:0]    flags_q
);
  localparam int HB = DW / 2;
  logic sa, sb;
  assign sa = word_sel ? op_a[DW-1] : op_a[HB-1];
  assign sb = word_sel ? op_b[DW-1] : op_b[HB-1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> flags_q == 6'd0);

  assert_zero_not_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[3] |-> !flags_q[4]);

  assert_zero_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[3] |-> flags_q[1]);

  assert_add_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_class == 2'd0 && sa != sb) |=> !flags_q[5]);

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_class[1]) |=> (!flags_q[0] && !flags_q[2] && !flags_q[5]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags_q));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
  .word_sel(word_sel), .op_class(op_class), .wr_en(wr_en), .flags_q(flags_q)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  logic        clk = 0;
  logic        rst_n;
  logic [15:0] op_a, op_b, result;
  logic        carry_out, word_sel, wr_en;
  logic [1:0]  op_class;
  logic [5:0]  flags_q;

  typedef struct { logic [5:0] f; string tag; } item_t;
  item_t q[$];
  logic [5:0] exp_state;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  alu_flag_unit #(.DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result),
    .carry_out(carry_out), .word_sel(word_sel), .op_class(op_class),
    .wr_en(wr_en), .flags_q(flags_q)
  );

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (flags_q !== it.f) begin
        errors++;
        $display("FAIL %s: flags actual %b expected %b", it.tag, flags_q, it.f);
      end
    end
  end

  // op: 0 add, 1 sub, 2/3 logic (AND when lx=0, XOR when lx=1)
  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [1:0] op,
                       input bit w, input bit wr, input bit lx, input logic [7:0] junk,
                       input string tag);
    longint W, mask, ua, ub, sum, r, sa, sb, s, half;
    bit c, fc, fa, fo;
    item_t it;
    W = w ? 16 : 8;
    mask = (longint'(1) << W) - 1;
    half = longint'(1) << (W - 1);
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    sa = (ua >= half) ? ua - (half * 2) : ua;
    sb = (ub >= half) ? ub - (half * 2) : ub;
    fc = 0; fa = 0; fo = 0;
    if (op == 2'd0) begin
      sum = ua + ub; r = sum & mask; c = ((sum >> W) & 1) != 0;
      fc = (ua + ub) > mask;
      fa = ((ua & 15) + (ub & 15)) > 15;
      s = sa + sb; fo = (s >= half) || (s < -half);
    end else if (op == 2'd1) begin
      sum = ua + ((~ub) & mask) + 1; r = sum & mask; c = ((sum >> W) & 1) != 0;
      fc = ua < ub;
      fa = (ua & 15) < (ub & 15);
      s = sa - sb; fo = (s >= half) || (s < -half);
    end else begin
      r = lx ? ((ua ^ ub) & mask) : ((ua & ub) & mask);
      c = 1'b1;
    end
    @(negedge clk);
    op_a = a; op_b = b; op_class = op; word_sel = w; wr_en = wr; carry_out = c;
    result = w ? 16'(r) : {junk, 8'(r)};
    if (wr)
      exp_state = {fo, (r >= half), (r == 0), fa,
                   ($countones(8'(r)) % 2 == 0), fc};
    it.f = exp_state; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 1; op_a = 16'hFFFF; op_b = 16'hFFFF; result = 16'hFFFF;
    carry_out = 1; word_sel = 1; op_class = 0;
    exp_state = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (flags_q !== 6'd0) begin
      errors++;
      $display("FAIL R1: flags actual %b expected %b", flags_q, 6'd0);
    end
    wr_en = 0; rst_n = 1;

    drive(16'h007F, 16'h0001, 0, 0, 1, 0, 8'hA5, "R7 byte add overflow");
    drive(16'hFFFF, 16'h0001, 0, 1, 1, 0, 8'h00, "R6 word add carry/zero");
    drive(16'h0000, 16'h0001, 1, 0, 1, 0, 8'h3C, "R6 byte sub borrow");
    drive(16'h8000, 16'h0001, 1, 1, 1, 0, 8'h00, "R7 word sub overflow");
    drive(16'h0010, 16'h0001, 1, 1, 1, 0, 8'h00, "R5 nibble borrow");
    drive(16'h0008, 16'h0008, 0, 1, 1, 0, 8'h00, "R5 nibble carry");
    drive(16'h1200, 16'h00FF, 2, 0, 1, 0, 8'hFF, "R3 byte zero ignores high");
    drive(16'h0300, 16'h0100, 2, 1, 1, 0, 8'h00, "R4 parity low byte only");
    drive(16'h8000, 16'h8000, 2, 1, 1, 0, 8'h00, "R2 word sign");
    drive(16'h00F0, 16'h0070, 3, 0, 1, 1, 8'h12, "R10 spare code as logic");
    drive(16'h007F, 16'h0001, 0, 0, 1, 0, 8'h00, "R8 setup");
    drive(16'h00FF, 16'h0081, 2, 0, 1, 0, 8'h00, "R8 logic clears C/A/O");
    drive(16'h7FFF, 16'hFFFF, 0, 1, 0, 0, 8'h00, "R9 hold without strobe");
    drive(16'h0000, 16'h0000, 1, 1, 0, 0, 8'h00, "R9 hold again");
    for (int i = 0; i < 400; i++)
      drive(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom),
            ($urandom % 4) != 0, 1'($urandom), 8'($urandom), "R2-R10 random mix");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule